// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is a clocked behavioural model of the control side of an 8-bit asynchronous DRAM. It is meant to sit on the far end of a memory controller under test. A fast clock oversamples the four active-low strobes: row strobe `ras_n`, column strobe `cas_n`, write enable `we_n` and output enable `oe_n`. The order in which the strobes change decides the kind of each memory cycle: read, early write, delayed write, read-modify-write, row-only refresh, refresh from the internal counter, hidden refresh or self refresh. The same order decides where the data is latched and when the data outputs are driven.

The row address is captured when the row strobe falls, unless the column strobe is already low at that moment. The column address is captured on every column strobe fall during an open row. A small behavioural array is addressed by the low bits of the row and the column, so that data written by the controller can be read back. An 11-bit refresh counter supplies the row for the refresh kinds that use the counter, and it advances after each use. A sticky flag records strobe pulses shorter than their configured minimum and row strobe low periods that are too long.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, `cyc_kind` is 0 (idle), `dq_oe` is 0, `timing_err` is 0, and the refresh counter holds 0.
- R2: A row strobe fall while the column strobe is high latches `addr` into `row_addr` and sets `cyc_kind` to 5 (row-only refresh). The kind stays 5 and `dq_oe` stays 0 while the column strobe stays high.
- R3: A row strobe fall while the column strobe is low sets `cyc_kind` to 6 (counter refresh) and puts the refresh counter value on `row_addr`. The counter then increments and wraps at 11 bits.
- R4: A column strobe fall with `we_n` low, in an open row, sets `cyc_kind` to 2 (early write), stores `dq_in` at the current row and column, and keeps `dq_out` disabled.
- R5: A column strobe fall with `we_n` high, in an open row, sets `cyc_kind` to 1 (read), latches `addr` into `col_addr` and loads the stored byte. `dq_oe` is 1 only while the read data is valid and `oe_n` is low.
- R6: A `we_n` fall during a read with the column strobe low stores `dq_in` at the latched column. The kind becomes 4 (read-modify-write) if read data was being driven at that time, and 3 (delayed write) otherwise.
- R7: `dq_oe` returns to 0 when `oe_n` goes high, when both strobes are high (which also sets `cyc_kind` to 0), or when `we_n` falls while the column strobe is high.
- R8: In page mode, the read data and `dq_oe` stay in place after the column strobe rises, until the next column strobe fall.
- R9: A row strobe fall with the column strobe still low from a valid read sets `cyc_kind` to 7 (hidden refresh). It uses and advances the counter, and the previous read data stays on `dq_out` with `dq_oe` unchanged.
- R10: After a counter refresh entry, keeping both strobes low for SELF_ENTRY further clocks sets `cyc_kind` to 8 (self refresh). From then on, every SELF_INT clocks the counter value goes to `row_addr` and the counter advances. Raising both strobes returns the kind to 0.
- R11: `timing_err` is set once the row strobe has been sampled low for more than RAS_MAX consecutive clocks, outside counter and self refresh. It stays set until reset.
- R12: `timing_err` is set when a low or high pulse of the row or column strobe lasts fewer clocks than its configured minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_AW | Multiplexed row/column address |
| dq_in | input | DATA_W | Write data from the controller |
| dq_out | output | DATA_W | Read data towards the controller |
| dq_oe | output | 1 | Read data is being driven |
| cyc_kind | output | 4 | Kind of the current cycle |
| row_addr | output | ROW_AW | Row in use (latched or from the refresh counter) |
| col_addr | output | COL_AW | Latched column |
| timing_err | output | 1 | Sticky strobe timing violation |

## Verification
The hardest situations to reach are the ones that depend on strobe history rather than on present levels. A hidden refresh needs a valid read still held on the outputs while the row strobe is cycled under a column strobe that stays low. Self refresh needs both strobes held low for a long, counted window after a counter refresh. The bench walks these sequences step by step with scaled-down entry and interval parameters. It tracks the expected counter value across counter, hidden and self refreshes, and it sweeps the counter through a full 11-bit wrap. Pulse-width and row-low limits are probed exactly at their boundaries, one clock short of the limit and one clock past it.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
    typedef enum logic [3:0] {
        CYC_IDLE     = 4'd0,
        CYC_READ     = 4'd1,
        CYC_EARLY_WR = 4'd2,
        CYC_DELAY_WR = 4'd3,
        CYC_RMW      = 4'd4,
        CYC_RAS_ONLY = 4'd5,
        CYC_CBR      = 4'd6,
        CYC_HIDDEN   = 4'd7,
        CYC_SELF     = 4'd8
    } dsd_cyc_e;
endpackage

// File: rtl/dsd_pulse_mon.sv
// Per-strobe sampler: edge detect, pulse width measurement, length limit.
module dsd_pulse_mon #(
    parameter int CNT_W    = 8,
    parameter int MIN_LOW  = 0,
    parameter int MIN_HIGH = 0,
    parameter int MAX_LOW  = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    output logic fall,
    output logic short_pulse,
    output logic long_low
);
    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } mon_t;

    mon_t d, q;
    logic edge_seen;

    assign edge_seen = (strb != q.lvl);

    always_comb begin
        d = q;
        if (edge_seen) begin
            d.lvl = strb;
            d.cnt = CNT_W'(1);
        end else if (q.cnt != {CNT_W{1'b1}}) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lvl <= 1'b1;
            q.cnt <= {CNT_W{1'b1}};
        end else begin
            q <= d;
        end
    end

    assign fall        = q.lvl & ~strb;
    assign short_pulse = edge_seen & (q.lvl ? (q.cnt < CNT_W'(MIN_HIGH))
                                            : (q.cnt < CNT_W'(MIN_LOW)));

    generate
        if (MAX_LOW > 0) begin : g_limit
            assign long_low = ~strb & ~q.lvl & (q.cnt >= CNT_W'(MAX_LOW));
        end else begin : g_nolimit
            assign long_low = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/dsd_array.sv
// Small behavioural storage array, write synchronous, read combinational.
module dsd_array #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << (ROW_W + COL_W);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[{wr_row, wr_col}] <= wr_data;
        end
    end

    assign rd_data = cells[{rd_row, rd_col}];
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import dsd_pkg::*;
#(
    parameter int ROW_AW       = 11,
    parameter int COL_AW       = 10,
    parameter int DATA_W       = 8,
    parameter int ARR_ROW_W    = 4,
    parameter int ARR_COL_W    = 4,
    parameter int RAS_MAX      = 25000,
    parameter int RAS_MIN_LOW  = 15,
    parameter int RAS_MIN_HIGH = 10,
    parameter int CAS_MIN_LOW  = 3,
    parameter int CAS_MIN_HIGH = 3,
    parameter int SELF_ENTRY   = 25000,
    parameter int SELF_INT     = 3900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ROW_AW-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [3:0]        cyc_kind,
    output logic [ROW_AW-1:0] row_addr,
    output logic [COL_AW-1:0] col_addr,
    output logic              timing_err
);
    localparam int NSTRB  = 3;
    localparam int LIM_A  = (RAS_MAX > RAS_MIN_LOW) ? RAS_MAX : RAS_MIN_LOW;
    localparam int LIM_B  = (RAS_MIN_HIGH > CAS_MIN_LOW) ? RAS_MIN_HIGH : CAS_MIN_LOW;
    localparam int LIM_C  = (LIM_A > LIM_B) ? LIM_A : LIM_B;
    localparam int LIM    = (LIM_C > CAS_MIN_HIGH) ? LIM_C : CAS_MIN_HIGH;
    localparam int CNT_W  = $clog2(LIM + 2);
    localparam int SC_LIM = (SELF_ENTRY > SELF_INT) ? SELF_ENTRY : SELF_INT;
    localparam int SC_W   = $clog2(SC_LIM + 1);
    localparam int MIN_LO [NSTRB] = '{RAS_MIN_LOW,  CAS_MIN_LOW,  0};
    localparam int MIN_HI [NSTRB] = '{RAS_MIN_HIGH, CAS_MIN_HIGH, 0};

    typedef struct packed {
        dsd_cyc_e          kind;
        logic [ROW_AW-1:0] row;
        logic [COL_AW-1:0] col;
        logic [ROW_AW-1:0] rfc;
        logic              valid;
        logic              drive;
        logic [DATA_W-1:0] dout;
        logic [SC_W-1:0]   self_cnt;
        logic              viol;
    } st_t;

    st_t d, q;

    // strobe index: 0 row strobe, 1 column strobe, 2 write enable
    logic [NSTRB-1:0] strb, fall_v, short_v, long_v;
    assign strb = {we_n, cas_n, ras_n};

    generate
        for (genvar g = 0; g < NSTRB; g++) begin : g_mon
            dsd_pulse_mon #(
                .CNT_W   (CNT_W),
                .MIN_LOW (MIN_LO[g]),
                .MIN_HIGH(MIN_HI[g]),
                .MAX_LOW ((g == 0) ? RAS_MAX : 0)
            ) u_mon (
                .clk        (clk),
                .rst_n      (rst_n),
                .strb       (strb[g]),
                .fall       (fall_v[g]),
                .short_pulse(short_v[g]),
                .long_low   (long_v[g])
            );
        end
    endgenerate

    logic                 rfall, cfall, wfall;
    logic                 wr_en;
    logic [ARR_COL_W-1:0] wr_col;
    logic [DATA_W-1:0]    rd_data;
    logic                 refresh_hold;

    assign rfall = fall_v[0];
    assign cfall = fall_v[1];
    assign wfall = fall_v[2];
    assign refresh_hold = (q.kind == CYC_CBR) || (q.kind == CYC_SELF);

    dsd_array #(
        .ROW_W (ARR_ROW_W),
        .COL_W (ARR_COL_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_row (q.row[ARR_ROW_W-1:0]),
        .wr_col (wr_col),
        .wr_data(dq_in),
        .rd_row (q.row[ARR_ROW_W-1:0]),
        .rd_col (addr[ARR_COL_W-1:0]),
        .rd_data(rd_data)
    );

    always_comb begin
        d      = q;
        wr_en  = 1'b0;
        wr_col = q.col[ARR_COL_W-1:0];

        if (rfall) begin
            if (!cas_n) begin
                d.row      = q.rfc;
                d.rfc      = q.rfc + 1'b1;
                d.self_cnt = '0;
                d.kind     = (q.kind == CYC_READ && q.valid) ? CYC_HIDDEN : CYC_CBR;
            end else begin
                d.row  = addr;
                d.kind = CYC_RAS_ONLY;
            end
        end else if (cfall && !ras_n && !refresh_hold && q.kind != CYC_HIDDEN) begin
            d.col = addr[COL_AW-1:0];
            if (!we_n) begin
                d.kind  = CYC_EARLY_WR;
                d.valid = 1'b0;
                wr_en   = 1'b1;
                wr_col  = addr[ARR_COL_W-1:0];
            end else begin
                d.kind  = CYC_READ;
                d.valid = 1'b1;
                d.dout  = rd_data;
            end
        end else if (wfall) begin
            if (!cas_n && !ras_n && q.kind == CYC_READ) begin
                wr_en  = 1'b1;
                d.kind = q.drive ? CYC_RMW : CYC_DELAY_WR;
            end else if (cas_n) begin
                d.valid = 1'b0;
            end
        end else if (!ras_n && !cas_n && refresh_hold) begin
            if (q.kind == CYC_CBR) begin
                if (q.self_cnt == SC_W'(SELF_ENTRY - 1)) begin
                    d.kind     = CYC_SELF;
                    d.self_cnt = '0;
                end else begin
                    d.self_cnt = q.self_cnt + 1'b1;
                end
            end else begin
                if (q.self_cnt == SC_W'(SELF_INT - 1)) begin
                    d.self_cnt = '0;
                    d.row      = q.rfc;
                    d.rfc      = q.rfc + 1'b1;
                end else begin
                    d.self_cnt = q.self_cnt + 1'b1;
                end
            end
        end

        if (ras_n && cas_n) begin
            d.valid    = 1'b0;
            d.kind     = CYC_IDLE;
            d.self_cnt = '0;
        end

        d.drive = d.valid & ~oe_n;
        d.viol  = q.viol | (|short_v) | ((|long_v) & ~refresh_hold);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{kind: CYC_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign dq_out     = q.dout;
    assign dq_oe      = q.drive;
    assign cyc_kind   = q.kind;
    assign row_addr   = q.row;
    assign col_addr   = q.col;
    assign timing_err = q.viol;
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker
    import dsd_pkg::*;
#(
    parameter int ROW_AW = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              oe_n,
    input logic [ROW_AW-1:0] addr,
    input logic              dq_oe,
    input logic [3:0]        cyc_kind,
    input logic [ROW_AW-1:0] row_addr,
    input logic              timing_err
);
    AST_ROW_ONLY_LATCH: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ras_n) && cas_n) |=> (cyc_kind == CYC_RAS_ONLY && row_addr == $past(addr))); // R2
    AST_ROW_ONLY_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (cyc_kind == CYC_RAS_ONLY) |-> !dq_oe); // R2
    AST_COUNTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ras_n) && !cas_n) |=> (cyc_kind == CYC_CBR || cyc_kind == CYC_HIDDEN)); // R3
    AST_EARLY_WR_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (cyc_kind == CYC_EARLY_WR) |-> !dq_oe); // R4
    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> $past(!oe_n)); // R5
    AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (ras_n && cas_n) |=> (!dq_oe && cyc_kind == CYC_IDLE)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) timing_err |=> timing_err); // R11
endmodule

bind dram_strobe_decoder dsd_checker #(.ROW_AW(ROW_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .oe_n      (oe_n),
    .addr      (addr),
    .dq_oe     (dq_oe),
    .cyc_kind  (cyc_kind),
    .row_addr  (row_addr),
    .timing_err(timing_err)
);

// File: tb/dram_strobe_decoder_tb.sv
`timescale 1ns/1ps
module dram_strobe_decoder_tb;
    localparam int AR   = 3;
    localparam int AC   = 3;
    localparam int RMAX = 200;
    localparam int SENT = 60;
    localparam int SINT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [3:0]  cyc_kind;
    logic [10:0] row_addr;
    logic [9:0]  col_addr;
    logic        timing_err;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    int   ref_exp = 0;
    logic [7:0] mem_exp [64];

    always #2 clk = ~clk;

    dram_strobe_decoder #(
        .ARR_ROW_W(AR), .ARR_COL_W(AC), .RAS_MAX(RMAX),
        .RAS_MIN_LOW(4), .RAS_MIN_HIGH(3), .CAS_MIN_LOW(2), .CAS_MIN_HIGH(2),
        .SELF_ENTRY(SENT), .SELF_INT(SINT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .cyc_kind(cyc_kind), .row_addr(row_addr), .col_addr(col_addr),
        .timing_err(timing_err)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int r, input int c);
        return 8'((r * 37 + c * 11 + 5) & 255);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(1);
        ref_exp = 0;
    endtask

    task automatic read_cell(input int r, input int c, input string tag);
        addr = 11'(r); ras_n = 1'b0; oe_n = 1'b0;
        step(2);
        addr = 11'(c); cas_n = 1'b0;
        step(2);
        chk(tag, int'(dq_out), int'(mem_exp[r * 8 + c]));
        chk(tag, int'(dq_oe), 1);
        cas_n = 1'b1;
        step(2);
        ras_n = 1'b1; oe_n = 1'b1;
        step(3);
    endtask

    task automatic cbr_once(input string tag);
        cas_n = 1'b0;
        step(2);
        ras_n = 1'b0;
        step(1);
        chk({tag, " kind"}, int'(cyc_kind), 6);
        chk({tag, " row"}, int'(row_addr), ref_exp);
        ref_exp = (ref_exp + 1) % 2048;
        step(3);
        ras_n = 1'b1;
        step(3);
        cas_n = 1'b1;
        step(2);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 kind", int'(cyc_kind), 0);
        chk("R1 dq_oe", int'(dq_oe), 0);
        chk("R1 err", int'(timing_err), 0);

        // R4 early-write sweep of every cell, page mode per row
        for (int r = 0; r < 8; r++) begin
            addr = 11'(r); ras_n = 1'b0;
            step(2);
            chk("R2 open kind", int'(cyc_kind), 5);
            chk("R2 open row", int'(row_addr), r);
            for (int c = 0; c < 8; c++) begin
                addr = 11'(c); dq_in = pat(r, c); mem_exp[r * 8 + c] = pat(r, c);
                we_n = 1'b0; cas_n = 1'b0;
                step(2);
                chk("R4 kind", int'(cyc_kind), 2);
                chk("R4 dq_oe", int'(dq_oe), 0);
                cas_n = 1'b1; we_n = 1'b1;
                step(2);
            end
            ras_n = 1'b1;
            step(3);
        end

        // R5 R8 page-mode read sweep
        for (int r = 0; r < 8; r++) begin
            addr = 11'(r); ras_n = 1'b0; oe_n = 1'b0;
            step(2);
            for (int c = 0; c < 8; c++) begin
                addr = 11'(c); cas_n = 1'b0;
                step(2);
                chk("R5 kind", int'(cyc_kind), 1);
                chk("R5 data", int'(dq_out), int'(mem_exp[r * 8 + c]));
                chk("R5 col", int'(col_addr), c);
                chk("R5 dq_oe", int'(dq_oe), 1);
                cas_n = 1'b1;
                step(2);
                chk("R8 held data", int'(dq_out), int'(mem_exp[r * 8 + c]));
                chk("R8 held oe", int'(dq_oe), 1);
            end
            ras_n = 1'b1;
            step(1);
            chk("R7 standby hiz", int'(dq_oe), 0);
            chk("R7 standby kind", int'(cyc_kind), 0);
            oe_n = 1'b1;
            step(2);
        end

        // R5 R7 output enable gating, then R6 delayed write
        addr = 11'd1; ras_n = 1'b0;
        step(2);
        addr = 11'd2; cas_n = 1'b0;
        step(2);
        chk("R5 oe high kind", int'(cyc_kind), 1);
        chk("R5 oe high hiz", int'(dq_oe), 0);
        oe_n = 1'b0;
        step(1);
        chk("R5 oe low drive", int'(dq_oe), 1);
        oe_n = 1'b1;
        step(1);
        chk("R7 oe high hiz", int'(dq_oe), 0);
        dq_in = 8'hA5; we_n = 1'b0;
        step(1);
        chk("R6 delayed kind", int'(cyc_kind), 3);
        mem_exp[1 * 8 + 2] = 8'hA5;
        we_n = 1'b1; cas_n = 1'b1;
        step(2);
        ras_n = 1'b1;
        step(3);
        read_cell(1, 2, "R6 delayed readback");

        // R6 read-modify-write
        addr = 11'd2; ras_n = 1'b0;
        step(2);
        addr = 11'd3; oe_n = 1'b0; cas_n = 1'b0;
        step(2);
        chk("R6 rmw read", int'(dq_out), int'(mem_exp[2 * 8 + 3]));
        dq_in = 8'h3C; we_n = 1'b0;
        step(1);
        chk("R6 rmw kind", int'(cyc_kind), 4);
        chk("R6 rmw old data", int'(dq_out), int'(mem_exp[2 * 8 + 3]));
        mem_exp[2 * 8 + 3] = 8'h3C;
        oe_n = 1'b1; we_n = 1'b1;
        step(1);
        cas_n = 1'b1;
        step(2);
        ras_n = 1'b1;
        step(3);
        read_cell(2, 3, "R6 rmw readback");

        // R7 write-enable fall with column strobe high
        addr = 11'd3; ras_n = 1'b0; oe_n = 1'b0;
        step(2);
        addr = 11'd1; cas_n = 1'b0;
        step(2);
        cas_n = 1'b1;
        step(2);
        chk("R8 page hold", int'(dq_oe), 1);
        we_n = 1'b0;
        step(1);
        chk("R7 we fall hiz", int'(dq_oe), 0);
        we_n = 1'b1;
        step(1);
        ras_n = 1'b1; oe_n = 1'b1;
        step(3);

        // R2 row-only refresh
        addr = 11'd5; ras_n = 1'b0; oe_n = 1'b0;
        step(6);
        chk("R2 kind", int'(cyc_kind), 5);
        chk("R2 row", int'(row_addr), 5);
        chk("R2 hiz", int'(dq_oe), 0);
        ras_n = 1'b1; oe_n = 1'b1;
        step(3);

        // R3 counter refresh sequence
        for (int i = 0; i < 3; i++) cbr_once("R3 cbr");

        // R9 hidden refresh
        addr = 11'd4; ras_n = 1'b0; oe_n = 1'b0;
        step(2);
        addr = 11'd6; cas_n = 1'b0;
        step(2);
        chk("R9 pre read", int'(dq_out), int'(mem_exp[4 * 8 + 6]));
        ras_n = 1'b1;
        step(3);
        chk("R9 between kind", int'(cyc_kind), 1);
        chk("R9 between oe", int'(dq_oe), 1);
        ras_n = 1'b0;
        step(1);
        chk("R9 kind", int'(cyc_kind), 7);
        chk("R9 row", int'(row_addr), ref_exp);
        chk("R9 data kept", int'(dq_out), int'(mem_exp[4 * 8 + 6]));
        chk("R9 oe kept", int'(dq_oe), 1);
        ref_exp = ref_exp + 1;
        step(3);
        ras_n = 1'b1;
        step(3);
        cas_n = 1'b1; oe_n = 1'b1;
        step(2);
        chk("R7 after hidden", int'(dq_oe), 0);

        // R10 self refresh
        cas_n = 1'b0;
        step(2);
        ras_n = 1'b0;
        step(1);
        chk("R10 entry cbr row", int'(row_addr), ref_exp);
        ref_exp = ref_exp + 1;
        step(SENT - 1);
        chk("R10 before entry", int'(cyc_kind), 6);
        step(1);
        chk("R10 entered", int'(cyc_kind), 8);
        step(SINT - 1);
        chk("R10 no tick yet", int'(row_addr), ref_exp - 1);
        step(1);
        chk("R10 first tick", int'(row_addr), ref_exp);
        ref_exp = ref_exp + 1;
        step(SINT);
        chk("R10 second tick", int'(row_addr), ref_exp);
        ref_exp = ref_exp + 1;
        ras_n = 1'b1; cas_n = 1'b1;
        step(1);
        chk("R10 exit", int'(cyc_kind), 0);
        step(2);
        cbr_once("R10 counter continues");

        chk("R11 R12 no false error", int'(timing_err), 0);

        // R11 row strobe held low too long
        addr = 11'd0; ras_n = 1'b0;
        step(RMAX);
        chk("R11 at limit", int'(timing_err), 0);
        step(1);
        chk("R11 past limit", int'(timing_err), 1);
        ras_n = 1'b1;
        step(3);
        chk("R11 sticky", int'(timing_err), 1);

        // R12 short column strobe low pulse
        do_reset();
        ras_n = 1'b0;
        step(2);
        cas_n = 1'b0;
        step(1);
        chk("R12 before", int'(timing_err), 0);
        cas_n = 1'b1;
        step(1);
        chk("R12 short cas", int'(timing_err), 1);
        step(2);
        ras_n = 1'b1;
        step(3);

        // R12 short row strobe precharge
        do_reset();
        ras_n = 1'b0;
        step(4);
        ras_n = 1'b1;
        step(1);
        chk("R12 min low ok", int'(timing_err), 0);
        ras_n = 1'b0;
        step(1);
        chk("R12 short precharge", int'(timing_err), 1);
        step(3);
        ras_n = 1'b1;
        step(3);

        // R3 full counter sweep with wrap
        do_reset();
        for (int i = 0; i < 2049; i++) cbr_once("R3 sweep");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule